// File: doc/BRIEF.md
# Board Interrupt Expander Controller

This block collects up to sixteen peripheral interrupt lines into one active-high level request toward a host processor. Each input is synchronized and then latched into a pending word. A separate enable word selects which pending lines may raise the host request. The host reaches both words over a 16-bit synchronous register bus. Enables are changed through two addresses, one that sets bits and one that clears them. Pending bits are acknowledged by writing ones. A read-only view of the synchronized input levels sits beside the latched word.

The block also reports the lowest-numbered line that is both enabled and pending, with a valid flag. A host handler that services lines from bit 0 upward can use this index directly instead of scanning the word. Reads return data one clock after the read strobe is sampled.

Top module: `irqx_top`

## Requirements
- R1: After reset, the pending word and the enable word are zero, `host_irq` and `first_valid` are low, and `bus_rdata` is zero.
- R2: Each input passes through two synchronizer flops. An input that goes high before a clock edge sets its pending bit on the third rising edge. The bit stays set after the input falls, until it is acknowledged.
- R3: Writing to byte offset 0x16 clears each pending bit whose data bit is 1 and leaves bits written as 0 unchanged. A read of 0x16 returns the pending word.
- R4: A read of offset 0x18 returns the synchronized live level of every input. This view is not latched, so it drops to 0 when the input falls.
- R5: Writing to offset 0x1A sets each enable bit whose data bit is 1. A read of 0x1A returns the whole enable word.
- R6: Writing to offset 0x1C clears each enable bit whose data bit is 1. A read of 0x1C returns the enable word and changes no state.
- R7: `host_irq` is high exactly when the bitwise AND of the pending word and the enable word is non-zero.
- R8: If an acknowledge and a set from a high synchronized input hit the same bit in the same cycle, the set wins. An input that is still high therefore re-latches after an acknowledge.
- R9: `first_valid` equals `host_irq`. When it is high, `first_idx` holds the index of the lowest-numbered line that is both enabled and pending. Otherwise `first_idx` is 0.
- R10: Reads of any offset other than 0x16, 0x18, 0x1A and 0x1C return 0. Writes to those offsets change neither word.
- R11: With all inputs low, writing 0xFFFF to 0x1C and then 0xFFFF to 0x16 leaves no line enabled and none pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_in | input | 16 | Asynchronous peripheral interrupt levels, active high |
| bus_addr | input | 8 | Byte offset of the register access |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 16 | Read data, valid one clock after the strobe |
| host_irq | output | 1 | Level request to the host processor |
| first_idx | output | 4 | Lowest enabled pending line |
| first_valid | output | 1 | `first_idx` is meaningful |

## Verification
Two events can land on the same pending bit in the same clock: an acknowledge write to 0x16, and a set from a synchronized input that is still high. The bench provokes this collision by holding an input high and then writing a one to that bit. It expects the bit to read back as 1, and `host_irq` to stay high if the line is enabled. It also acknowledges the bit again after the input has fallen and expects the bit to read back as 0. Random stimulus mixes input changes with acknowledges of random masks, so some acknowledged bits are live and some are not. Each outcome is compared with a bench model.

// File: rtl/irqx_pkg.sv
package irqx_pkg;

    // Byte offsets of the register map
    localparam int unsigned OFS_PEND  = 32'h16;
    localparam int unsigned OFS_LEVEL = 32'h18;
    localparam int unsigned OFS_ENSET = 32'h1A;
    localparam int unsigned OFS_ENCLR = 32'h1C;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_PEND,
        SEL_LEVEL,
        SEL_ENSET,
        SEL_ENCLR
    } reg_sel_e;

endpackage

// File: rtl/irqx_sync.sv
module irqx_sync #(
    parameter int unsigned WIDTH  = 16,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[s] <= '0;
                else        stage_q[s] <= async_in;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[s] <= '0;
                else        stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/irqx_core.sv
module irqx_core #(
    parameter int unsigned LINES = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] set_lvl,
    input  logic [LINES-1:0] ack_mask,
    input  logic [LINES-1:0] en_set_mask,
    input  logic [LINES-1:0] en_clr_mask,
    output logic [LINES-1:0] pend_q,
    output logic [LINES-1:0] en_q
);

    typedef struct packed {
        logic [LINES-1:0] pend;
        logic [LINES-1:0] en;
    } core_state_t;

    core_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // acknowledge first, then live level sets: set wins on collision
        st_d.pend = (st_q.pend & ~ack_mask) | set_lvl;
        st_d.en   = (st_q.en | en_set_mask) & ~en_clr_mask;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend_q = st_q.pend;
    assign en_q   = st_q.en;

endmodule

// File: rtl/irqx_prio.sv
module irqx_prio #(
    parameter int unsigned LINES = 16,
    localparam int unsigned IDX_W = (LINES > 1) ? $clog2(LINES) : 1
) (
    input  logic [LINES-1:0] req,
    output logic [IDX_W-1:0] idx,
    output logic             valid
);

    always_comb begin
        idx   = '0;
        valid = 1'b0;
        // walk downward so the lowest set bit is written last
        for (int i = LINES - 1; i >= 0; i--) begin
            if (req[i]) begin
                idx   = IDX_W'(i);
                valid = 1'b1;
            end
        end
    end

endmodule

// File: rtl/irqx_top.sv
module irqx_top #(
    parameter int unsigned LINES  = 16,
    parameter int unsigned ADDR_W = 8,
    localparam int unsigned IDX_W = (LINES > 1) ? $clog2(LINES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LINES-1:0]  irq_in,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [LINES-1:0]  bus_wdata,
    input  logic              bus_rd,
    output logic [LINES-1:0]  bus_rdata,
    output logic              host_irq,
    output logic [IDX_W-1:0]  first_idx,
    output logic              first_valid
);

    import irqx_pkg::*;

    logic [LINES-1:0] sync_lvl;
    logic [LINES-1:0] pend_w;
    logic [LINES-1:0] en_w;
    logic [LINES-1:0] ack_mask;
    logic [LINES-1:0] en_set_mask;
    logic [LINES-1:0] en_clr_mask;
    logic [LINES-1:0] active;
    reg_sel_e         sel;

    typedef struct packed {
        logic [LINES-1:0] rdata;
    } rd_state_t;

    rd_state_t rd_d, rd_q;

    irqx_sync #(.WIDTH(LINES), .STAGES(2)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (irq_in),
        .sync_out (sync_lvl)
    );

    // address decode
    always_comb begin
        if      (bus_addr == ADDR_W'(OFS_PEND))  sel = SEL_PEND;
        else if (bus_addr == ADDR_W'(OFS_LEVEL)) sel = SEL_LEVEL;
        else if (bus_addr == ADDR_W'(OFS_ENSET)) sel = SEL_ENSET;
        else if (bus_addr == ADDR_W'(OFS_ENCLR)) sel = SEL_ENCLR;
        else                                     sel = SEL_NONE;
    end

    always_comb begin
        ack_mask    = '0;
        en_set_mask = '0;
        en_clr_mask = '0;
        if (bus_wr) begin
            unique case (sel)
                SEL_PEND:  ack_mask    = bus_wdata;
                SEL_ENSET: en_set_mask = bus_wdata;
                SEL_ENCLR: en_clr_mask = bus_wdata;
                default:   ;
            endcase
        end
    end

    irqx_core #(.LINES(LINES)) u_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .set_lvl     (sync_lvl),
        .ack_mask    (ack_mask),
        .en_set_mask (en_set_mask),
        .en_clr_mask (en_clr_mask),
        .pend_q      (pend_w),
        .en_q        (en_w)
    );

    // read data path, registered
    always_comb begin
        rd_d = rd_q;
        if (bus_rd) begin
            unique case (sel)
                SEL_PEND:  rd_d.rdata = pend_w;
                SEL_LEVEL: rd_d.rdata = sync_lvl;
                SEL_ENSET: rd_d.rdata = en_w;
                SEL_ENCLR: rd_d.rdata = en_w;
                default:   rd_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign bus_rdata = rd_q.rdata;
    assign active    = pend_w & en_w;
    assign host_irq  = |active;

    irqx_prio #(.LINES(LINES)) u_prio (
        .req   (active),
        .idx   (first_idx),
        .valid (first_valid)
    );

endmodule

// File: rtl/irqx_chk.sv
module irqx_chk #(
    parameter int unsigned LINES  = 16,
    parameter int unsigned ADDR_W = 8,
    localparam int unsigned IDX_W = (LINES > 1) ? $clog2(LINES) : 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic [LINES-1:0]  bus_wdata,
    input logic              bus_rd,
    input logic [LINES-1:0]  bus_rdata,
    input logic              host_irq,
    input logic [IDX_W-1:0]  first_idx,
    input logic              first_valid,
    input logic [LINES-1:0]  sync_lvl,
    input logic [LINES-1:0]  pend_w,
    input logic [LINES-1:0]  en_w
);

    import irqx_pkg::*;

    logic [LINES-1:0] below_mask;
    logic             unmapped;

    assign below_mask = (LINES'(1) << first_idx) - LINES'(1);
    assign unmapped   = (bus_addr != ADDR_W'(OFS_PEND))  && (bus_addr != ADDR_W'(OFS_LEVEL)) &&
                        (bus_addr != ADDR_W'(OFS_ENSET)) && (bus_addr != ADDR_W'(OFS_ENCLR));

    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pend_w == '0 && en_w == '0 && bus_rdata == '0));

    assert_sync_latch_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_lvl != '0) |=> ((pend_w & $past(sync_lvl)) == $past(sync_lvl)));

    assert_ack_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(OFS_PEND)) |=>
        ((pend_w & $past(bus_wdata) & ~$past(sync_lvl)) == '0));

    assert_enable_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(OFS_ENSET)) |=>
        ((en_w & $past(bus_wdata)) == $past(bus_wdata)));

    assert_enable_clr_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(OFS_ENCLR)) |=> ((en_w & $past(bus_wdata)) == '0));

    assert_host_matches_R7: assert property (@(posedge clk) disable iff (!rst_n)
        host_irq == first_valid);

    assert_first_lowest_R9: assert property (@(posedge clk) disable iff (!rst_n)
        first_valid |-> (pend_w[first_idx] && en_w[first_idx] &&
                         ((pend_w & en_w & below_mask) == '0)));

    assert_unmapped_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && unmapped) |=> (bus_rdata == '0));

    assert_unmapped_wr_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && unmapped) |=> ($stable(en_w)));

endmodule

bind irqx_top irqx_chk #(.LINES(LINES), .ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_addr    (bus_addr),
    .bus_wr      (bus_wr),
    .bus_wdata   (bus_wdata),
    .bus_rd      (bus_rd),
    .bus_rdata   (bus_rdata),
    .host_irq    (host_irq),
    .first_idx   (first_idx),
    .first_valid (first_valid),
    .sync_lvl    (sync_lvl),
    .pend_w      (pend_w),
    .en_w        (en_w)
);

// File: tb/tb_irqx_top.sv
module tb_irqx_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] irq_in = '0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic        bus_rd = 1'b0;
    logic [15:0] bus_rdata;
    logic        host_irq;
    logic [3:0]  first_idx;
    logic        first_valid;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    logic [15:0] st_m = '0;
    logic [15:0] en_m = '0;
    logic [15:0] in_m = '0;

    always #4 clk = ~clk;   // 125 MHz

    irqx_top dut (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rd(bus_rd),
        .bus_rdata(bus_rdata), .host_irq(host_irq), .first_idx(first_idx),
        .first_valid(first_valid)
    );

    function automatic logic [15:0] exp_rd(input logic [7:0] a);
        case (a)
            8'h16:        return st_m;
            8'h18:        return in_m;
            8'h1A, 8'h1C: return en_m;
            default:      return 16'h0;
        endcase
    endfunction

    function automatic int exp_first(input logic [15:0] v);
        for (int i = 0; i < 16; i++) if (v[i]) return i;
        return 0;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic set_inputs(input logic [15:0] v);
        @(negedge clk);
        irq_in = v;
        repeat (4) @(negedge clk);
        in_m = v;
        st_m = st_m | v;
    endtask

    task automatic check_outputs(input string req);
        chk(req, {31'd0, host_irq}, {31'd0, |(st_m & en_m)});
        chk("R9", {31'd0, first_valid}, {31'd0, |(st_m & en_m)});
        chk("R9", {28'd0, first_idx}, exp_first(st_m & en_m));
    endtask

    task automatic check_read(input string req, input logic [7:0] a);
        logic [15:0] d;
        bus_read(a, d);
        chk(req, {16'd0, d}, {16'd0, exp_rd(a)});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [15:0] d;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1", {31'd0, host_irq}, 32'd0);
        chk("R1", {31'd0, first_valid}, 32'd0);
        chk("R1", {16'd0, bus_rdata}, 32'd0);
        rst_n = 1'b1;
        check_read("R1", 8'h16);
        check_read("R1", 8'h1A);

        // R2 latency: enable line 5, raise input, request appears after third edge
        bus_write(8'h1A, 16'h0020); en_m = 16'h0020;
        @(negedge clk); irq_in = 16'h0020;
        @(negedge clk); chk("R2", {31'd0, host_irq}, 32'd0);
        @(negedge clk); chk("R2", {31'd0, host_irq}, 32'd0);
        @(negedge clk); chk("R2", {31'd0, host_irq}, 32'd1);
        in_m = 16'h0020; st_m = 16'h0020;
        check_outputs("R7");
        // R4 live view, then drop input: R2 latch holds, R4 view falls
        check_read("R4", 8'h18);
        set_inputs(16'h0000);
        check_read("R4", 8'h18);
        check_read("R2", 8'h16);

        // R8 set beats acknowledge while line is still high
        set_inputs(16'h0101);
        bus_write(8'h1A, 16'h0100); en_m = en_m | 16'h0100;
        bus_write(8'h16, 16'h0101); st_m = (st_m & ~16'h0101) | in_m;
        check_read("R8", 8'h16);
        chk("R8", {31'd0, host_irq}, 32'd1);
        // R3 ack after fall clears; zero bits leave others
        set_inputs(16'h0000);
        bus_write(8'h16, 16'h0001); st_m = st_m & ~16'h0001;
        check_read("R3", 8'h16);
        bus_write(8'h16, 16'h0000);
        check_read("R3", 8'h16);
        // R9 lowest index
        check_outputs("R9");

        // R6 read of clear address has no side effect
        check_read("R6", 8'h1C);
        check_read("R6", 8'h1C);
        check_read("R5", 8'h1A);

        // R10 unmapped
        bus_write(8'h00, 16'hFFFF);
        bus_write(8'h17, 16'hFFFF);
        check_read("R10", 8'h00);
        check_read("R10", 8'h1E);
        check_read("R10", 8'h1A);
        check_read("R10", 8'h16);

        // random mix
        for (int n = 0; n < 300; n++) begin
            int op;
            logic [15:0] v;
            op = int'($urandom % 6);
            v  = 16'($urandom);
            case (op)
                0: set_inputs(v & 16'($urandom));
                1: begin bus_write(8'h1A, v); en_m = en_m | v; end
                2: begin bus_write(8'h1C, v); en_m = en_m & ~v; end
                3: begin bus_write(8'h16, v); st_m = (st_m & ~v) | in_m; end
                4: check_read("R3", 8'h16);
                default: check_read("R5", 8'h1A);
            endcase
            check_outputs("R7");
        end
        check_read("R4", 8'h18);
        check_read("R6", 8'h1C);

        // R11 bulk clear
        set_inputs(16'h0000);
        bus_write(8'h1C, 16'hFFFF); en_m = '0;
        bus_write(8'h16, 16'hFFFF); st_m = '0;
        check_read("R11", 8'h1A);
        check_read("R11", 8'h16);
        chk("R11", {31'd0, host_irq}, 32'd0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule